// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block is the configuring side of a master serial load. After power-up, or after a reconfigure request on an active-low program input, it holds its initialisation output low for a fixed time. It then toggles a configuration clock derived from the system clock and captures one serial data bit on every rising edge of that clock. Once the expected number of bits has arrived, it parks the clock and raises its done output. The received bits are packed into words and presented with a one-cycle valid strobe.

The two status outputs can be wired straight to an external serial memory. The active-low initialisation output resets the memory's address pointer. The done output stays low for the whole load, which keeps the memory's chip enable active, and goes high when the load completes. A mode input selects a slow (1.25 MHz) or fast (10 MHz) configuration clock. Program pulses shorter than a minimum length are treated as glitches and ignored.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset is released, `init_n` stays low for exactly POR_CYCLES + INIT_CYCLES system cycles. `done` and `cclk` are low during that time, and a load follows.
- R2: A low on `prgm_n` lasting at least PRGM_MIN system cycles (500 ns = 100 cycles qualifies) restarts the block from any state. `init_n` and `done` go low and stay low while `prgm_n` remains low. After `prgm_n` returns high, `init_n` stays low for SYNC_STAGES + INIT_CYCLES samples.
- R3: A low on `prgm_n` shorter than PRGM_MIN cycles has no effect. A running load completes with all of its bits, and a finished load keeps `done` high.
- R4: While loading, every half period of `cclk` lasts SYS_HZ/(2*SLOW_HZ) system cycles when `slow_sel` is 1 (1.25 MHz) and SYS_HZ/(2*FAST_HZ) cycles when it is 0 (10 MHz).
- R5: `din` is captured at the system edge where `cclk` rises. Every WORD_W captured bits are presented on `cfg_word`, with the first received bit in the MSB. `word_vld` is a one-cycle pulse in the cycle after the capture that completes the word.
- R6: `done` stays low during the load and rises directly after the BIT_LEN-th rising `cclk` edge. After that, `cclk` stays low and `done` stays high until a restart.
- R7: When a qualified restart falls on the same edge as the final bit capture, the restart wins: `done` never rises, and a complete new load follows.
- R8: `done` is never high while `init_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| prgm_n | input | 1 | Asynchronous active-low reconfigure request |
| slow_sel | input | 1 | 1 selects the slow configuration clock, 0 the fast one |
| din | input | 1 | Serial configuration data |
| cclk | output | 1 | Configuration clock |
| init_n | output | 1 | Low while initialising; resets the external memory's address pointer |
| done | output | 1 | Low while loading, high once the load is complete |
| cfg_word | output | WORD_W | Last assembled word, first bit in the MSB |
| word_vld | output | 1 | One-cycle strobe for a new `cfg_word` |

## Verification
The reconfigure path and the end-of-stream detector can act on the same system edge. In that case a restart must cancel the completion instead of letting `done` blink high. The bench provokes this by counting rising `cclk` edges and releasing a qualifying `prgm_n` pulse at the offset that makes the filtered request fire on the edge that captures the last bit. That offset is computed from the half period, the synchroniser depth and the minimum pulse length. The collision is judged correct when `done` is never seen high around it, `init_n` goes low, and a full fresh load of BIT_LEN bits then completes.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [1:0] {
    ST_POR  = 2'd0,
    ST_INIT = 2'd1,
    ST_LOAD = 2'd2,
    ST_DONE = 2'd3
  } cfg_state_e;

  // System cycles in one half period of the configuration clock
  function automatic int half_cycles(input int sys_hz, input int clk_hz);
    int r;
    r = sys_hz / (2 * clk_hz);
    if (r < 1) r = 1;
    return r;
  endfunction

  // Bits needed to hold the value max_val
  function automatic int cnt_width(input int max_val);
    int w;
    w = $clog2(max_val + 1);
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/cfgld_prgm_filter.sv
module cfgld_prgm_filter
  import cfgld_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prgm_n,
  output logic prgm_lvl,
  output logic restart
);
  localparam int LW = cnt_width(MIN_LOW);
  localparam logic [LW-1:0] LOW_LAST = LW'(MIN_LOW - 1);
  localparam logic [LW-1:0] LOW_SAT  = LW'(MIN_LOW);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [LW-1:0]          low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], prgm_n};
  end

  assign prgm_lvl = sync_q[SYNC_STAGES-1];

  // Length of the current synchronised low run, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_cnt <= '0;
    else if (prgm_lvl)          low_cnt <= '0;
    else if (low_cnt != LOW_SAT) low_cnt <= low_cnt + 1'b1;
  end

  // Fires once, in the cycle the run reaches the minimum length
  assign restart = !prgm_lvl && (low_cnt == LOW_LAST);

endmodule

// File: rtl/cfgld_cclk_gen.sv
module cfgld_cclk_gen
  import cfgld_pkg::*;
#(
  parameter int HALF_FAST = 10,
  parameter int HALF_SLOW = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic slow_sel,
  output logic cclk,
  output logic rise_evt
);
  localparam int HALF_MAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int CW = cnt_width(HALF_MAX);
  localparam logic [CW-1:0] FAST_LAST = CW'(HALF_FAST - 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(HALF_SLOW - 1);

  logic [CW-1:0] ph_cnt;
  logic [CW-1:0] ph_last;
  logic          cclk_q;
  logic          tick;

  assign ph_last  = slow_sel ? SLOW_LAST : FAST_LAST;
  assign tick     = en && (ph_cnt >= ph_last);
  assign rise_evt = tick && !cclk_q;
  assign cclk     = cclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_cnt <= '0;
      cclk_q <= 1'b0;
    end else if (!en) begin
      ph_cnt <= '0;
      cclk_q <= 1'b0;
    end else if (tick) begin
      ph_cnt <= '0;
      cclk_q <= ~cclk_q;
    end else begin
      ph_cnt <= ph_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cfgld_bit_shifter.sv
module cfgld_bit_shifter
  import cfgld_pkg::*;
#(
  parameter int BIT_LEN = 64,
  parameter int WORD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic              word_vld,
  output logic              last_cap
);
  localparam int BW = cnt_width(BIT_LEN);
  localparam int PW = cnt_width(WORD_W - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(BIT_LEN - 1);
  localparam logic [PW-1:0] POS_LAST = PW'(WORD_W - 1);

  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] shift_nx;
  logic [BW-1:0]     bit_cnt;
  logic [PW-1:0]     wpos;

  assign shift_nx = {shift_q[WORD_W-2:0], din};
  assign last_cap = cap && (bit_cnt == BIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      bit_cnt  <= '0;
      wpos     <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else if (clr) begin
      shift_q  <= '0;
      bit_cnt  <= '0;
      wpos     <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (cap) begin
        shift_q <= shift_nx;
        bit_cnt <= bit_cnt + 1'b1;
        if (wpos == POS_LAST) begin
          wpos     <= '0;
          word     <= shift_nx;
          word_vld <= 1'b1;
        end else begin
          wpos <= wpos + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgld_pkg::*;
#(
  parameter int SYS_HZ      = 200_000_000,
  parameter int FAST_HZ     = 10_000_000,
  parameter int SLOW_HZ     = 1_250_000,
  parameter int BIT_LEN     = 64,
  parameter int WORD_W      = 8,
  parameter int POR_CYCLES  = 8,
  parameter int INIT_CYCLES = 32,
  parameter int PRGM_MIN    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prgm_n,
  input  logic              slow_sel,
  input  logic              din,
  output logic              cclk,
  output logic              init_n,
  output logic              done,
  output logic [WORD_W-1:0] cfg_word,
  output logic              word_vld
);
  localparam int HALF_FAST = half_cycles(SYS_HZ, FAST_HZ);
  localparam int HALF_SLOW = half_cycles(SYS_HZ, SLOW_HZ);
  localparam int SEQ_MAX   = (POR_CYCLES > INIT_CYCLES) ? POR_CYCLES : INIT_CYCLES;
  localparam int SW        = cnt_width(SEQ_MAX);
  localparam logic [SW-1:0] POR_LAST  = SW'(POR_CYCLES - 1);
  localparam logic [SW-1:0] INIT_LAST = SW'(INIT_CYCLES - 1);

  cfg_state_e    state;
  logic [SW-1:0] seq_cnt;

  // Named internal events shared with the checker
  logic prgm_lvl;
  logic restart;
  logic rise_evt;
  logic last_cap;
  logic loading;
  logic shf_clr;

  cfgld_prgm_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_LOW    (PRGM_MIN)
  ) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .prgm_n  (prgm_n),
    .prgm_lvl(prgm_lvl),
    .restart (restart)
  );

  cfgld_cclk_gen #(
    .HALF_FAST(HALF_FAST),
    .HALF_SLOW(HALF_SLOW)
  ) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (loading),
    .slow_sel(slow_sel),
    .cclk    (cclk),
    .rise_evt(rise_evt)
  );

  cfgld_bit_shifter #(
    .BIT_LEN(BIT_LEN),
    .WORD_W (WORD_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (shf_clr),
    .cap     (rise_evt),
    .din     (din),
    .word    (cfg_word),
    .word_vld(word_vld),
    .last_cap(last_cap)
  );

  // Sequencer: a restart outranks every other transition
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_POR;
      seq_cnt <= '0;
    end else if (restart) begin
      state   <= ST_INIT;
      seq_cnt <= '0;
    end else begin
      unique case (state)
        ST_POR: begin
          if (seq_cnt == POR_LAST) begin
            state   <= ST_INIT;
            seq_cnt <= '0;
          end else begin
            seq_cnt <= seq_cnt + 1'b1;
          end
        end
        ST_INIT: begin
          if (!prgm_lvl) begin
            seq_cnt <= '0;
          end else if (seq_cnt == INIT_LAST) begin
            state   <= ST_LOAD;
            seq_cnt <= '0;
          end else begin
            seq_cnt <= seq_cnt + 1'b1;
          end
        end
        ST_LOAD: begin
          if (last_cap) state <= ST_DONE;
        end
        ST_DONE: begin
          state <= ST_DONE;
        end
        default: state <= ST_POR;
      endcase
    end
  end

  assign loading = (state == ST_LOAD);
  assign init_n  = !((state == ST_POR) || (state == ST_INIT));
  assign done    = (state == ST_DONE);
  assign shf_clr = !init_n || restart;

endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic init_n,
  input logic done,
  input logic cclk,
  input logic restart,
  input logic sample_evt,
  input logic last_cap,
  input logic word_vld,
  input logic prgm_lvl
);

  AST_INIT_BLOCKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |-> !done); // R8

  AST_RESTART_TO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!init_n && !done)); // R2

  AST_INIT_HELD_BY_PRGM: assert property (@(posedge clk) disable iff (!rst_n)
    (!prgm_lvl && !init_n) |=> !init_n); // R2

  AST_SAMPLE_ONLY_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> (init_n && !done)); // R5

  AST_WORD_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld); // R5

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cap && !restart) |=> done); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> done); // R6

  AST_CCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> !cclk); // R6

  AST_COLLIDE_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cap && restart) |=> (!done && !init_n)); // R7

endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .init_n    (init_n),
  .done      (done),
  .cclk      (cclk),
  .restart   (restart),
  .sample_evt(rise_evt),
  .last_cap  (last_cap),
  .word_vld  (word_vld),
  .prgm_lvl  (prgm_lvl)
);

// File: tb/tb_cfg_serial_loader.sv
`timescale 1ns/1ps
module tb_cfg_serial_loader;
  localparam int SYS_HZ      = 200_000_000;
  localparam int FAST_HZ     = 10_000_000;
  localparam int SLOW_HZ     = 1_250_000;
  localparam int BIT_LEN     = 64;
  localparam int WORD_W      = 8;
  localparam int POR_CYCLES  = 8;
  localparam int INIT_CYCLES = 32;
  localparam int PRGM_MIN    = 16;
  localparam int SYNC_STAGES = 2;
  localparam int WATCHDOG    = 190_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prgm_n = 1'b1;
  logic slow_sel = 1'b0;
  logic din = 1'b0;
  logic cclk, init_n, done, word_vld;
  logic [WORD_W-1:0] cfg_word;

  always #2.5 clk = ~clk;

  cfg_serial_loader #(
    .SYS_HZ(SYS_HZ), .FAST_HZ(FAST_HZ), .SLOW_HZ(SLOW_HZ),
    .BIT_LEN(BIT_LEN), .WORD_W(WORD_W), .POR_CYCLES(POR_CYCLES),
    .INIT_CYCLES(INIT_CYCLES), .PRGM_MIN(PRGM_MIN), .SYNC_STAGES(SYNC_STAGES)
  ) dut (
    .clk(clk), .rst_n(rst_n), .prgm_n(prgm_n), .slow_sel(slow_sel), .din(din),
    .cclk(cclk), .init_n(init_n), .done(done), .cfg_word(cfg_word), .word_vld(word_vld)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int rises   = 0;
  int wi      = 0;
  int last_rise = 0;
  logic cclk_d = 1'b0;
  logic bits [BIT_LEN];
  event mon_ev;

  function automatic int half_of(input logic slow);
    return SYS_HZ / (2 * (slow ? SLOW_HZ : FAST_HZ));
  endfunction

  function automatic logic [WORD_W-1:0] exp_word(input int k);
    logic [WORD_W-1:0] w;
    for (int i = 0; i < WORD_W; i++) w[WORD_W-1-i] = bits[k*WORD_W + i];
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic new_stream();
    for (int i = 0; i < BIT_LEN; i++) bits[i] = 1'($urandom_range(0, 1));
  endtask

  // Monitor: bit source, clock period and word checks, sampled at negedge
  always @(negedge clk) begin
    cyc++;
    if (!init_n) begin
      rises = 0;
      wi    = 0;
      din   = bits[0];
    end else begin
      if (cclk && !cclk_d) begin
        if (rises > 0)
          check((cyc - last_rise) == 2*half_of(slow_sel), "R4", "cclk period",
                cyc - last_rise, 2*half_of(slow_sel));
        last_rise = cyc;
        rises++;
        din = (rises < BIT_LEN) ? bits[rises] : 1'b0;
      end
      if (word_vld) begin
        check(cfg_word == exp_word(wi), "R5", "cfg_word", cfg_word, exp_word(wi));
        wi++;
      end
    end
    cclk_d = cclk;
    if (cyc > WATCHDOG) begin
      check(1'b0, "WDOG", "watchdog cycles", cyc, WATCHDOG);
      finish_run();
    end
    -> mon_ev;
  end

  task automatic wait_done(input string req);
    int t;
    t = 0;
    while (!done && t < 40000) begin
      @(mon_ev);
      t++;
    end
    check(done == 1'b1, req, "done after load", done, 1);
    check(rises == BIT_LEN, req, "rising cclk edges in load", rises, BIT_LEN);
    repeat (3) @(mon_ev);
    check(cclk == 1'b0, "R6", "cclk parked", cclk, 0);
    check(done == 1'b1, "R6", "done held", done, 1);
  endtask

  task automatic pulse(input int width);
    prgm_n = 1'b0;
    repeat (width) @(mon_ev);
    prgm_n = 1'b1;
  endtask

  task automatic wait_loading();
    while (!init_n) @(mon_ev);
  endtask

  initial begin
    int n;
    int d;
    logic seen_done;
    void'($urandom(32'h5EED_C0F1));
    new_stream();
    repeat (3) @(mon_ev);
    // R1 reset state
    check(init_n == 1'b0, "R1", "init_n in reset", init_n, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(cclk == 1'b0, "R1", "cclk in reset", cclk, 0);
    rst_n = 1'b1;
    n = 0;
    while (!init_n && n < 1000) begin n++; @(mon_ev); end
    check(n == POR_CYCLES + INIT_CYCLES, "R1", "init_n low cycles after reset",
          n, POR_CYCLES + INIT_CYCLES);
    wait_done("R6");

    // R3: short pulse while done
    pulse(PRGM_MIN - 1);
    repeat (4) @(mon_ev);
    check(done == 1'b1 && init_n == 1'b1, "R3", "short pulse in done (done,init_n)",
          {done, init_n}, 2'b11);

    // R2: 500 ns pulse, slow mode
    new_stream();
    slow_sel = 1'b1;
    prgm_n = 1'b0;
    repeat (100) @(mon_ev);
    check(init_n == 1'b0, "R2", "init_n while prgm held", init_n, 0);
    check(done == 1'b0, "R2", "done while prgm held", done, 0);
    prgm_n = 1'b1;
    n = 0;
    while (!init_n && n < 1000) begin n++; @(mon_ev); end
    check(n == SYNC_STAGES + INIT_CYCLES, "R2", "init_n low after prgm release",
          n, SYNC_STAGES + INIT_CYCLES);
    wait_done("R6");

    // R2 boundary width, then R3 short pulse mid-load
    slow_sel = 1'b0;
    new_stream();
    pulse(PRGM_MIN);
    repeat (3) @(mon_ev);
    check(init_n == 1'b0, "R2", "minimum-width pulse restarts", init_n, 0);
    wait_loading();
    while (rises < BIT_LEN/2) @(mon_ev);
    pulse(PRGM_MIN - 1);
    repeat (3) @(mon_ev);
    check(init_n == 1'b1, "R3", "short pulse mid-load", init_n, 1);
    wait_done("R3");

    // R7: restart on the final capture edge
    new_stream();
    pulse(PRGM_MIN + 2);
    repeat (3) @(mon_ev);
    wait_loading();
    while (rises < BIT_LEN - 1) @(mon_ev);
    d = 2*half_of(1'b0) - SYNC_STAGES - PRGM_MIN;
    if (d < 0) d = 0;
    seen_done = 1'b0;
    repeat (d) @(mon_ev);
    prgm_n = 1'b0;
    for (int i = 0; i < PRGM_MIN + 4; i++) begin
      @(mon_ev);
      if (done) seen_done = 1'b1;
    end
    prgm_n = 1'b1;
    check(seen_done == 1'b0, "R7", "done rose despite colliding restart", seen_done, 0);
    check(init_n == 1'b0, "R7", "init_n after collision", init_n, 0);
    wait_done("R7");

    // Random mix: mode, restart widths, short glitches at random points
    for (int it = 0; it < 5; it++) begin
      int wl, ws, dl;
      slow_sel = 1'($urandom_range(0, 1));
      new_stream();
      wl = PRGM_MIN + int'($urandom_range(0, 40));
      pulse(wl);
      repeat (3) @(mon_ev);
      check(init_n == 1'b0, "R2", "random long pulse restarts", init_n, 0);
      wait_loading();
      dl = int'($urandom_range(0, BIT_LEN * half_of(slow_sel)));
      repeat (dl) @(mon_ev);
      ws = int'($urandom_range(1, PRGM_MIN - 1));
      pulse(ws);
      repeat (3) @(mon_ev);
      check(init_n == 1'b1, "R3", "random short pulse ignored", init_n, 1);
      check(!(done == 1'b1 && init_n == 1'b0), "R8", "done with init_n low",
            {done, init_n}, 2'b01);
      wait_done("R6");
    end

    finish_run();
  end
endmodule